// File: doc/BRIEF.md
# Multi-Output Clock Crossbar with Two-Stage Gated Division

This block generates several derived clocks from a shared set of parent clocks. Each output channel has a crossbar selector that picks one parent. The picked clock then runs through a pre-divider, which has its own enable gate, and then through a final divider, which also has its own enable gate. Software sets up every channel through a small word-addressed register bus. The parent inputs may be asynchronous. The block samples them with its own clock through a two-flop synchronizer, and every output is a registered level in that clock domain. Parents must therefore run well below half the block clock rate.

The register layout is fixed because software decodes it. Four channels share each crossbar word, one byte lane per channel. Each pre-divider ratio has a word of its own. Each final-divider word holds both the ratio and the final gate. To enable a channel, software sets both gates. To disable it, software clears only the final gate, so the pre-divider keeps running. A channel counts as enabled while its final gate is set. There is no streaming data path, so the bus and the clock outputs are plain control pins with no handshake.

Top module: `clkxbar_gen`

## Requirements
- R1: After reset, every select field, gate bit and ratio field reads 0, and every output is low.
- R2: The bus uses word addresses. Channel i has four fields:
  - Its select is bits [5:0] and its pre-gate is bit 6 of byte lane (i mod 4) in the crossbar word at address 6 + floor(i/4).
  - Its pre-divider ratio is bits [9:0] of the word at 22 + i.
  - Its final ratio is bits [5:0] and its final gate is bit 6 of the word at 89 + i.
  - A write lands on the clock edge that samples bus_wr high. The read data is combinational from bus_addr.
- R3: Reads return 0 for unused bits, for lanes beyond the last channel and for unmapped words. Writes to those locations have no effect.
- R4: The select field picks the parent with the same index. A select value at or above the number of parents gives a constant low source, so the output makes no further rising edges.
- R5: A ratio field holding N divides by N+1, and a field of 0 passes the clock through. The output period is the parent period times (P+1)·(F+1), where P and F are the pre and final ratio fields.
- R6: Each divider ratio R keeps the output high for floor(R/2) of its input periods. Even ratios give a 50% duty cycle, and odd ratios give a high phase one input period shorter than the low phase. The final stage sets the output high time when F > 0. The pre stage sets it when F = 0.
- R7: When the final gate is clear, the output is low from the clock edge after the one that stored the clear. Clearing the final gate leaves the pre-gate bit unchanged. Setting the final gate again restores the configured period.
- R8: When the pre-gate is clear and the final gate is set, the output makes no rising edge. With F = 0, the output is low within three clock edges.
- R9: Channels are independent. Configuring one channel leaves the period of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| parent_clk | input | NPAR | Parent clocks, possibly asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| clk_out | output | NOUT | Divided, gated output clocks |

## Verification
A wrong stored field shows on the read port in the cycle after the write, because reads are combinational. A wrong divider counter or threshold shows up one output period later: the distance between two rising edges and the high time change, so the bench measures both over full periods once the output has settled. A gate that fails to block the clock shows as an output rising edge within about three clock edges after the gate clears. The bench therefore watches for any high level or rising edge over a long window after each gate or select change.

// File: rtl/ckxb_pkg.sv
package ckxb_pkg;
  // word addresses where each register group starts
  localparam int XB_WORD = 6;
  localparam int PD_WORD = 22;
  localparam int FD_WORD = 89;
  // field widths
  localparam int SEL_W  = 6;
  localparam int PD_W   = 10;
  localparam int FD_W   = 6;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int DW     = 32;
endpackage

// File: rtl/ckxb_sync.sv
module ckxb_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/ckxb_regs.sv
module ckxb_regs
  import ckxb_pkg::*;
#(
  parameter int NOUT = 6,
  parameter int AW   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [AW-1:0]              bus_addr,
  input  logic [DW-1:0]              bus_wdata,
  output logic [DW-1:0]              bus_rdata,
  output logic [NOUT-1:0][SEL_W-1:0] sel,
  output logic [NOUT-1:0]            pgate,
  output logic [NOUT-1:0][PD_W-1:0]  pdiv,
  output logic [NOUT-1:0]            fgate,
  output logic [NOUT-1:0][FD_W-1:0]  fdiv
);
  logic [DW-1:0] rd_part [NOUT];

  for (genvar i = 0; i < NOUT; i++) begin : g_ch
    localparam int XA = XB_WORD + i / LANES;
    localparam int PA = PD_WORD + i;
    localparam int FA = FD_WORD + i;
    localparam int SH = (i % LANES) * LANE_W;

    logic [SEL_W-1:0] sel_q;
    logic             pg_q;
    logic [PD_W-1:0]  pd_q;
    logic             fg_q;
    logic [FD_W-1:0]  fd_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q <= '0;
        pg_q  <= 1'b0;
        pd_q  <= '0;
        fg_q  <= 1'b0;
        fd_q  <= '0;
      end else if (bus_wr) begin
        if (bus_addr == AW'(XA)) begin
          sel_q <= bus_wdata[SH +: SEL_W];
          pg_q  <= bus_wdata[SH + SEL_W];
        end
        if (bus_addr == AW'(PA)) pd_q <= bus_wdata[PD_W-1:0];
        if (bus_addr == AW'(FA)) begin
          fd_q <= bus_wdata[FD_W-1:0];
          fg_q <= bus_wdata[FD_W];
        end
      end
    end

    assign sel[i]   = sel_q;
    assign pgate[i] = pg_q;
    assign pdiv[i]  = pd_q;
    assign fgate[i] = fg_q;
    assign fdiv[i]  = fd_q;

    assign rd_part[i] = (bus_addr == AW'(XA)) ? (DW'({pg_q, sel_q}) << SH)
                      : (bus_addr == AW'(PA)) ? DW'(pd_q)
                      : (bus_addr == AW'(FA)) ? DW'({fg_q, fd_q})
                      : '0;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NOUT; i++) bus_rdata = bus_rdata | rd_part[i];
  end
endmodule

// File: rtl/ckxb_divstage.sv
module ckxb_divstage #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_lvl,
  input  logic         gate_en,
  input  logic [W-1:0] ratio,
  output logic         out_lvl
);
  logic         gated, gated_q, rise, out_q;
  logic [W-1:0] cnt_q, cnt_nx;
  logic [W:0]   high_len;

  assign gated    = src_lvl & gate_en;
  assign rise     = gated & ~gated_q;
  // high phase spans floor((ratio+1)/2) input periods
  assign high_len = ({1'b0, ratio} + (W+1)'(1)) >> 1;
  assign cnt_nx   = (cnt_q >= ratio) ? '0 : cnt_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gated_q <= 1'b0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
    end else begin
      gated_q <= gated;
      if (!gate_en) begin
        cnt_q <= ratio;       // next input edge starts a fresh high phase
        out_q <= 1'b0;
      end else if (ratio == '0) begin
        out_q <= gated;       // pass-through with one register of latency
      end else if (rise) begin
        cnt_q <= cnt_nx;
        out_q <= ({1'b0, cnt_nx} < high_len);
      end
    end
  end

  assign out_lvl = out_q;
endmodule

// File: rtl/ckxb_chan.sv
module ckxb_chan
  import ckxb_pkg::*;
#(
  parameter int NPAR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAR-1:0]  par_lvl,
  input  logic [SEL_W-1:0] sel,
  input  logic             pgate,
  input  logic [PD_W-1:0]  pdiv,
  input  logic             fgate,
  input  logic [FD_W-1:0]  fdiv,
  output logic             out_lvl
);
  logic picked, mid_lvl;

  always_comb begin
    picked = 1'b0;
    for (int k = 0; k < NPAR; k++)
      if (sel == SEL_W'(k)) picked = par_lvl[k];
  end

  ckxb_divstage #(.W(PD_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .src_lvl(picked), .gate_en(pgate),
    .ratio(pdiv), .out_lvl(mid_lvl)
  );

  ckxb_divstage #(.W(FD_W)) u_fin (
    .clk(clk), .rst_n(rst_n), .src_lvl(mid_lvl), .gate_en(fgate),
    .ratio(fdiv), .out_lvl(out_lvl)
  );
endmodule

// File: rtl/clkxbar_gen.sv
module clkxbar_gen
  import ckxb_pkg::*;
#(
  parameter int NOUT = 6,
  parameter int NPAR = 8,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPAR-1:0] parent_clk,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NOUT-1:0] clk_out
);
  logic [NPAR-1:0]            par_lvl;
  logic [NOUT-1:0][SEL_W-1:0] ch_sel;
  logic [NOUT-1:0]            pgate_en;
  logic [NOUT-1:0][PD_W-1:0]  ch_pdiv;
  logic [NOUT-1:0]            fgate_en;
  logic [NOUT-1:0][FD_W-1:0]  ch_fdiv;

  ckxb_sync #(.N(NPAR)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(parent_clk), .sync_out(par_lvl)
  );

  ckxb_regs #(.NOUT(NOUT), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sel(ch_sel), .pgate(pgate_en), .pdiv(ch_pdiv),
    .fgate(fgate_en), .fdiv(ch_fdiv)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    ckxb_chan #(.NPAR(NPAR)) u_chan (
      .clk(clk), .rst_n(rst_n), .par_lvl(par_lvl),
      .sel(ch_sel[i]), .pgate(pgate_en[i]), .pdiv(ch_pdiv[i]),
      .fgate(fgate_en[i]), .fdiv(ch_fdiv[i]), .out_lvl(clk_out[i])
    );
  end
endmodule

// File: rtl/ckxb_chk.sv
module ckxb_chk
  import ckxb_pkg::*;
#(
  parameter int NOUT = 6,
  parameter int NPAR = 8,
  parameter int AW   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic [AW-1:0]              bus_addr,
  input logic [31:0]                bus_wdata,
  input logic [31:0]                bus_rdata,
  input logic [NOUT-1:0]            clk_out,
  input logic [NOUT-1:0]            pgate_en,
  input logic [NOUT-1:0]            fgate_en,
  input logic [NOUT-1:0][SEL_W-1:0] ch_sel
);
  localparam int NXB = (NOUT + LANES - 1) / LANES;

  logic in_xb, in_pd, in_fd;
  assign in_xb = int'(bus_addr) >= XB_WORD && int'(bus_addr) < XB_WORD + NXB;
  assign in_pd = int'(bus_addr) >= PD_WORD && int'(bus_addr) < PD_WORD + NOUT;
  assign in_fd = int'(bus_addr) >= FD_WORD && int'(bus_addr) < FD_WORD + NOUT;

  // R1
  rst_quiet_chk: assert property (@(negedge clk) !rst_n |-> clk_out == '0);

  // R3
  pd_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_pd |-> bus_rdata[31:PD_W] == '0);
  // R3
  fd_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fd |-> bus_rdata[31:FD_W+1] == '0);
  // R3
  xb_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_xb |-> (bus_rdata & 32'h8080_8080) == '0);
  // R3
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_xb || in_pd || in_fd) |-> bus_rdata == '0);

  for (genvar i = 0; i < NOUT; i++) begin : g_c
    // R2
    pd_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_wr && bus_addr == AW'(PD_WORD + i)) && bus_addr == AW'(PD_WORD + i))
      |-> bus_rdata[PD_W-1:0] == $past(bus_wdata[PD_W-1:0]));
    // R7
    fgate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fgate_en[i] |=> !clk_out[i]);
    // R8
    pgate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pgate_en[i] && !$past(pgate_en[i]) && !$past(pgate_en[i], 2) && !$past(pgate_en[i], 3))
      |-> !$rose(clk_out[i]));
    // R4
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ch_sel[i]) >= NPAR && int'($past(ch_sel[i])) >= NPAR &&
       int'($past(ch_sel[i], 2)) >= NPAR && int'($past(ch_sel[i], 3)) >= NPAR)
      |-> !$rose(clk_out[i]));
  end
endmodule

bind clkxbar_gen ckxb_chk #(.NOUT(NOUT), .NPAR(NPAR), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_out(clk_out),
  .pgate_en(pgate_en), .fgate_en(fgate_en), .ch_sel(ch_sel)
);

// File: tb/clkxbar_gen_bench.sv
`timescale 1ns/1ps
module clkxbar_gen_bench;
  localparam int NOUT = 6;
  localparam int NPAR = 8;
  localparam int AW   = 8;
  localparam int XB = 6, PD = 22, FD = 89;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPAR-1:0] par = '0;
  logic            bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NOUT-1:0] clk_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int pc [NPAR] = '{default: 0};

  // bench shadow of crossbar lanes
  int sh_sel [NOUT] = '{default: 0};
  int sh_pg  [NOUT] = '{default: 0};

  always #2 clk = ~clk;

  // parent p toggles every p+2 block cycles
  always @(posedge clk)
    for (int p = 0; p < NPAR; p++)
      if (pc[p] == p + 1) begin pc[p] <= 0; par[p] <= ~par[p]; end
      else pc[p] <= pc[p] + 1;

  clkxbar_gen #(.NOUT(NOUT), .NPAR(NPAR), .AW(AW)) u_clkxbar_gen (
    .clk(clk), .rst_n(rst_n), .parent_clk(par), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_out(clk_out)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic cfg(int ch, int sel, int pg, int p, int fg, int f);
    logic [31:0] w;
    int base;
    sh_sel[ch] = sel; sh_pg[ch] = pg;
    base = (ch / 4) * 4;
    w = '0;
    for (int j = 0; j < 4; j++)
      if (base + j < NOUT) w[j*8 +: 7] = {1'(sh_pg[base+j]), 6'(sh_sel[base+j])};
    wr(PD + ch, 32'(p));
    wr(FD + ch, {25'b0, 1'(fg), 6'(f)});
    wr(XB + ch / 4, w);
  endtask

  task automatic wait_rise(int ch, output bit ok);
    bit prev;
    ok = 0;
    @(negedge clk); prev = clk_out[ch];
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (clk_out[ch] && !prev) begin ok = 1; break; end
      prev = clk_out[ch];
    end
  endtask

  task automatic measure(int ch, output int hi, output int per);
    bit ok, prev;
    hi = -1; per = -1;
    for (int s = 0; s < 3; s++) begin
      wait_rise(ch, ok);
      if (!ok) return;
    end
    hi = 1; per = 1; prev = 1;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (clk_out[ch] && !prev) return;
      per++;
      if (clk_out[ch]) hi++;
      prev = clk_out[ch];
    end
    per = -1;
  endtask

  function automatic int exp_per(int sel, int p, int f);
    return 2 * (sel + 2) * (p + 1) * (f + 1);
  endfunction

  function automatic int exp_hi(int sel, int p, int f);
    int pp = 2 * (sel + 2);
    if (f > 0) return ((f + 1) / 2) * pp * (p + 1);
    if (p > 0) return ((p + 1) / 2) * pp;
    return sel + 2;
  endfunction

  task automatic run_ch(string req, int ch, int sel, int p, int f);
    int hi, per;
    measure(ch, hi, per);
    chk({req, " period"}, per, exp_per(sel, p, f));
    chk({req, " high"}, hi, exp_hi(sel, p, f));
  endtask

  task automatic quiet(string req, int ch, int cycles);
    int highs = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (clk_out[ch]) highs++;
    end
    chk(req, highs, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    int nz = 0;
    chk("R1 outputs low", int'(clk_out), 0);
    for (int a = 0; a < 128; a++) begin
      rd(a, d);
      if (d != 0) nz++;
    end
    chk("R1 all registers zero", nz, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(PD + 1, 32'hFFFF_FFFF); rd(PD + 1, d); chk("R2 R3 pre ratio field", int'(d), 32'h3FF);
    wr(FD + 2, 32'hFFFF_FFFF); rd(FD + 2, d); chk("R2 R3 final field", int'(d), 32'h7F);
    wr(XB + 1, 32'hFFFF_FFFF); rd(XB + 1, d); chk("R2 R3 crossbar lanes", int'(d), 32'h7F7F);
    wr(XB, 32'h0000_2A00);     rd(XB, d);     chk("R2 lane 1 select", int'(d), 32'h2A00);
    wr(2, 32'hFFFF_FFFF);      rd(2, d);      chk("R3 unmapped word", int'(d), 0);
    rd(PD + NOUT, d);                         chk("R3 beyond last channel", int'(d), 0);
    wr(PD + 1, 0); wr(FD + 2, 0); wr(XB + 1, 0); wr(XB, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regmap();
    // R4 R5 pass-through from parent 3
    cfg(0, 3, 1, 0, 1, 0);
    run_ch("R4 R5 bypass ch0", 0, 3, 0, 0);
    // R5 R6 even pre ratio
    cfg(1, 0, 1, 3, 1, 0);
    run_ch("R5 R6 pre even ch1", 1, 0, 3, 0);
    // R6 odd final ratio
    cfg(2, 1, 1, 1, 1, 2);
    run_ch("R6 final odd ch2", 2, 1, 1, 2);
    // R6 odd pre ratio
    cfg(3, 2, 1, 4, 1, 0);
    run_ch("R6 pre odd ch3", 3, 2, 4, 0);
    // R9 earlier channels unaffected
    run_ch("R9 ch0 unchanged", 0, 3, 0, 0);
    run_ch("R9 ch1 unchanged", 1, 0, 3, 0);
    // R5 extremes on the second crossbar word
    cfg(4, 0, 1, 1023, 1, 0);
    run_ch("R5 max pre ratio ch4", 4, 0, 1023, 0);
    cfg(5, 0, 1, 0, 1, 63);
    run_ch("R5 R6 max final ratio ch5", 5, 0, 0, 63);
    // R7 final gate off
    begin
      logic [31:0] d;
      wr(FD + 0, 32'h0);
      @(negedge clk);
      quiet("R7 final gate off low", 0, 60);
      rd(XB, d);
      chk("R7 pre gate kept", int'(d[6]), 1);
      wr(FD + 0, 32'h40);
      run_ch("R7 re-enable ch0", 0, 3, 0, 0);
    end
    // R8 pre gate off with final gate on
    cfg(1, 0, 0, 3, 1, 0);
    repeat (3) @(negedge clk);
    quiet("R8 pre gate off low", 1, 80);
    // R4 select beyond parent count
    cfg(3, 50, 1, 4, 1, 0);
    repeat (3) @(negedge clk);
    quiet("R4 out-of-range select low", 3, 100);
    run_ch("R9 ch2 unchanged", 2, 1, 1, 2);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule